// File: doc/BRIEF.md
# Serial DAC Write Controller

This block sits on the host side of a 14-bit serial-input DAC and turns parallel write requests into correctly timed serial frames. A client offers a 14-bit code with a valid/ready handshake. The controller builds a 16-bit word from the code, followed by two zero padding bits, and sends it MSB first. It drives an active-low chip-select, a serial clock and a data line. In four-wire mode it also drives a separate active-low load strobe that updates the converter output after the word has been shifted in.

Every interval is a parameter counted in system-clock cycles, and each must be at least 1. The intervals are: the chip-select lead before the first clock rise, the clock high and low phases, the chip-select hold after the last clock fall, the gap from chip-select rising to the load strobe, and the strobe width. Choosing these counts sets the serial clock rate, its duty cycle and the setup margins, so the device limits can be met from any faster system clock. After reset the controller will not accept a request until a power-up wait of `PWRUP_CYC` cycles has passed. The load-strobe option is chosen for each request by a mode input, which is sampled when the request is accepted.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, `dac_csn` is 1, `dac_sclk` is 0, `dac_ldn` is 1 and `req_ready` is 0.
- R2: `req_ready` first becomes 1 exactly `PWRUP_CYC` clock cycles after reset is released, and no frame starts before then.
- R3: A frame has exactly 16 rising edges of `dac_sclk` while `dac_csn` is 0. The bits on `dac_din` at those edges are the 14 code bits, bit 13 first, followed by two 0 bits.
- R4: Each high phase of `dac_sclk` lasts `SCK_HI_CYC` cycles. Each low phase between two rising edges of a frame lasts `SCK_LO_CYC` cycles.
- R5: The first rising edge of `dac_sclk` comes `CS_LEAD_CYC` cycles after `dac_csn` falls.
- R6: `dac_din` changes only while `dac_sclk` is low, and it holds its value in the cycle before each rising edge, so each bit is shifted out at a falling edge.
- R7: `dac_sclk` is 0 whenever `dac_csn` is 1.
- R8: `dac_csn` rises `CS_HOLD_CYC` cycles after the last falling edge of `dac_sclk` in the frame.
- R9: When `strobe_mode` is 1 at acceptance, `dac_ldn` stays 1 while `dac_csn` is 0. It falls `LD_GAP_CYC` cycles after `dac_csn` rises and stays 0 for `LD_PULSE_CYC` cycles.
- R10: When `strobe_mode` is 0 at acceptance, `dac_ldn` stays 1 for the whole transfer.
- R11: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1, and `dac_csn` is 0 in the next cycle. `req_ready` then stays 0 until the frame and any strobe are complete. In three-wire mode it returns in the cycle `dac_csn` rises; in four-wire mode it returns in the cycle `dac_ldn` rises. Changes to `req_code` and `strobe_mode` after acceptance have no effect on the frame in flight.
- R12: If `req_valid` is held at 1, the next frame begins in the cycle right after `req_ready` returns, and it carries the code present at that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_code | input | 14 | DAC code for the request |
| strobe_mode | input | 1 | 1: issue the load strobe after the frame |
| req_ready | output | 1 | Controller can take a request |
| dac_csn | output | 1 | Active-low chip select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_din | output | 1 | Serial data, MSB first |
| dac_ldn | output | 1 | Active-low load strobe |

## Verification
The hardest case to reach from the ports is a request held valid across a whole transfer. It checks two things: that changes to the code and mode during a busy period are ignored, and that the next frame starts without a single idle cycle. The stimulus leaves `req_valid` high after acceptance, swaps in a new code and an inverted mode at once, and then checks both the bits of the frame in flight and the start cycle of the following frame. Cycle-exact phase lengths are checked with non-default, asymmetric high and low counts, so that swapped or off-by-one phase timers show up.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP,
    ST_STRB
  } sdac_st_e;

  function automatic int sdac_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdac_pwrup_gate.sv
module sdac_pwrup_gate #(
  parameter int PWRUP_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int PW_W = $clog2(PWRUP_CYC + 1);

  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign done   = (cnt_q == PW_W'(PWRUP_CYC));
  assign cnt_en = !done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PWRUP_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R2

endmodule

// File: rtl/sdac_frame_shifter.sv
module sdac_frame_shifter #(
  parameter int CODE_W  = 14,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              last_bit
);

  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int BC_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BC_W-1:0]    bc_q, bc_d;

  always_comb begin
    sh_d = sh_q;
    bc_d = bc_q;
    if (load) begin
      sh_d = {code, {PAD_W{1'b0}}};
      bc_d = '0;
    end else if (shift) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
      bc_d = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= '0;
    end else begin
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign sdo      = sh_q[FRAME_W-1];
  assign last_bit = (bc_q == BC_W'(FRAME_W - 1));

  AST_NO_SHIFT_PAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |-> !shift); // R3

endmodule

// File: rtl/sdac_wr_ctrl.sv
module sdac_wr_ctrl
  import sdac_pkg::*;
#(
  parameter int CODE_W       = 14,
  parameter int FRAME_W      = 16,
  parameter int PWRUP_CYC    = 2000,
  parameter int CS_LEAD_CYC  = 5,
  parameter int SCK_HI_CYC   = 5,
  parameter int SCK_LO_CYC   = 5,
  parameter int CS_HOLD_CYC  = 5,
  parameter int LD_GAP_CYC   = 5,
  parameter int LD_PULSE_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              strobe_mode,
  output logic              req_ready,
  output logic              dac_csn,
  output logic              dac_sclk,
  output logic              dac_din,
  output logic              dac_ldn
);

  localparam int MAX_PH = sdac_max(sdac_max(sdac_max(CS_LEAD_CYC, SCK_HI_CYC),
                                            sdac_max(SCK_LO_CYC, CS_HOLD_CYC)),
                                   sdac_max(LD_GAP_CYC, LD_PULSE_CYC));
  localparam int TMR_W  = sdac_max($clog2(MAX_PH), 1);

  sdac_st_e   st_q, st_d;
  logic       csn_q, csn_d;
  logic       sclk_q, sclk_d;
  logic       ldn_q, ldn_d;
  logic       mode_q, mode_d;
  logic       tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic       tmr_exp;
  logic       pwr_done;
  logic       frm_load, frm_shift, frm_last, frm_sdo;
  logic       accept;

  sdac_pwrup_gate #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
    .clk   (clk),
    .rst_n (rst_n),
    .done  (pwr_done)
  );

  sdac_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sdac_frame_shifter #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frm_load),
    .code     (req_code),
    .shift    (frm_shift),
    .sdo      (frm_sdo),
    .last_bit (frm_last)
  );

  assign req_ready = (st_q == ST_IDLE) && pwr_done;
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_d      = st_q;
    csn_d     = csn_q;
    sclk_d    = sclk_q;
    ldn_d     = ldn_q;
    mode_d    = mode_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    frm_load  = 1'b0;
    frm_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        frm_load = 1'b1;
        mode_d   = strobe_mode;
        csn_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CS_LEAD_CYC - 1);
        st_d     = ST_LEAD;
      end
      ST_LEAD: if (tmr_exp) begin
        sclk_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SCK_HI_CYC - 1);
        st_d     = ST_HIGH;
      end
      ST_HIGH: if (tmr_exp) begin
        sclk_d   = 1'b0;
        tmr_load = 1'b1;
        if (frm_last) begin
          tmr_val = TMR_W'(CS_HOLD_CYC - 1);
          st_d    = ST_HOLD;
        end else begin
          frm_shift = 1'b1;
          tmr_val   = TMR_W'(SCK_LO_CYC - 1);
          st_d      = ST_LOW;
        end
      end
      ST_LOW: if (tmr_exp) begin
        sclk_d   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(SCK_HI_CYC - 1);
        st_d     = ST_HIGH;
      end
      ST_HOLD: if (tmr_exp) begin
        csn_d = 1'b1;
        if (mode_q) begin
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(LD_GAP_CYC - 1);
          st_d     = ST_GAP;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_GAP: if (tmr_exp) begin
        ldn_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(LD_PULSE_CYC - 1);
        st_d     = ST_STRB;
      end
      ST_STRB: if (tmr_exp) begin
        ldn_d = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
      ldn_q  <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      csn_q  <= csn_d;
      sclk_q <= sclk_d;
      ldn_q  <= ldn_d;
      mode_q <= mode_d;
    end
  end

  assign dac_csn  = csn_q;
  assign dac_sclk = sclk_q;
  assign dac_ldn  = ldn_q;
  assign dac_din  = frm_sdo;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_csn |-> !dac_sclk); // R7
  AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sclk |-> $stable(dac_din)); // R6
  AST_LDN_HIGH_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_csn |-> dac_ldn); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_csn || !dac_ldn) |-> !req_ready); // R11
  AST_NO_READY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> !req_ready); // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !dac_csn); // R11

endmodule

// File: tb/tb_sdac_wr_ctrl.sv
module tb_sdac_wr_ctrl;

  localparam int PW   = 300;
  localparam int LEAD = 5;
  localparam int HI   = 4;
  localparam int LO   = 6;
  localparam int HOLD = 3;
  localparam int GAP  = 5;
  localparam int PUL  = 7;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [13:0] req_code;
  logic        strobe_mode;
  logic        req_ready, dac_csn, dac_sclk, dac_din, dac_ldn;

  int n_tests = 0;
  int n_fail  = 0;

  sdac_wr_ctrl #(
    .CODE_W(14), .FRAME_W(16), .PWRUP_CYC(PW), .CS_LEAD_CYC(LEAD),
    .SCK_HI_CYC(HI), .SCK_LO_CYC(LO), .CS_HOLD_CYC(HOLD),
    .LD_GAP_CYC(GAP), .LD_PULSE_CYC(PUL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .strobe_mode(strobe_mode), .req_ready(req_ready), .dac_csn(dac_csn),
    .dac_sclk(dac_sclk), .dac_din(dac_din), .dac_ldn(dac_ldn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; strobe_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(dac_csn == 1'b1, "R1 csn", int'(dac_csn), 1);
    chk(dac_sclk == 1'b0, "R1 sclk", int'(dac_sclk), 0);
    chk(dac_ldn == 1'b1, "R1 ldn", int'(dac_ldn), 1);
    chk(req_ready == 1'b0, "R1 ready", int'(req_ready), 0);
  endtask

  task automatic t_powerup;
    int k = 0;
    int early_start = 0;
    rst_n = 1'b1;
    req_valid = 1'b1; req_code = 14'h1555;
    while (!req_ready && k < 5000) begin
      @(negedge clk);
      k++;
      if (!dac_csn && !req_ready) early_start++;
    end
    req_valid = 1'b0;
    chk(k == PW, "R2 power-up wait", k, PW);
    chk(early_start == 0, "R2 no frame before ready", early_start, 0);
    chk(dac_csn == 1'b1, "R1 csn after power-up", int'(dac_csn), 1);
  endtask

  task automatic run_frame(input logic [13:0] code, input logic mode,
                           input logic chain, input logic [13:0] nxt);
    int idx = 0;
    int lead = -1, nrise = 0, hi_run = 0, lo_run = 0;
    int hi_err = 0, lo_err = 0, din_err = 0, sck_idle_err = 0, ld_err = 0;
    int last_fall = -1, cs_rise = -1, ld_fall = -1, ld_rise = -1, end_idx = -1;
    int expd;
    logic prev_sclk = 1'b0, prev_din = 1'b0;
    logic [15:0] bits = '0;
    while (!req_ready) @(negedge clk);
    req_code = code; strobe_mode = mode; req_valid = 1'b1;
    @(posedge clk); #1;
    if (chain) req_code = nxt; else req_valid = 1'b0;
    strobe_mode = ~mode;
    while (idx < 3000) begin
      @(negedge clk);
      if (idx == 0) chk(dac_csn == 1'b0, "R11/R12 accepted, csn low next cycle", int'(dac_csn), 0);
      if (!dac_csn) begin
        if (!dac_ldn) ld_err++;
        if (dac_sclk && !prev_sclk) begin
          if (lead < 0) lead = idx;
          if (dac_din != prev_din) din_err++;
          bits = {bits[14:0], dac_din};
          nrise++;
          if (nrise > 1 && lo_run != LO) lo_err++;
          hi_run = 1;
        end else if (dac_sclk) begin
          if (dac_din != prev_din) din_err++;
          hi_run++;
        end else if (prev_sclk) begin
          if (hi_run != HI) hi_err++;
          lo_run = 1;
          last_fall = idx;
        end else begin
          lo_run++;
        end
      end else begin
        if (dac_sclk) sck_idle_err++;
        if (cs_rise < 0) cs_rise = idx;
        if (!dac_ldn && ld_fall < 0) ld_fall = idx;
        if (dac_ldn && ld_fall >= 0 && ld_rise < 0) ld_rise = idx;
      end
      prev_sclk = dac_sclk;
      prev_din  = dac_din;
      if (req_ready) begin end_idx = idx; break; end
      idx++;
    end
    chk(nrise == 16, "R3 rising edge count", nrise, 16);
    chk(bits == {code, 2'b00}, "R3 frame bits", int'(bits), int'({code, 2'b00}));
    chk(hi_err == 0, "R4 high phase length", hi_err, 0);
    chk(lo_err == 0, "R4 low phase length", lo_err, 0);
    chk(lead == LEAD, "R5 csn lead", lead, LEAD);
    chk(din_err == 0, "R6 din stable around rise", din_err, 0);
    chk(sck_idle_err == 0, "R7 sclk low while deselected", sck_idle_err, 0);
    chk(cs_rise - last_fall == HOLD, "R8 csn hold", cs_rise - last_fall, HOLD);
    if (mode) begin
      chk(ld_err == 0, "R9 ldn high during frame", ld_err, 0);
      chk(ld_fall - cs_rise == GAP, "R9 strobe gap", ld_fall - cs_rise, GAP);
      chk(ld_rise - ld_fall == PUL, "R9 strobe width", ld_rise - ld_fall, PUL);
    end else begin
      chk(ld_fall < 0 && ld_err == 0, "R10 no strobe", ld_fall, -1);
    end
    expd = LEAD + 16*HI + 15*LO + HOLD + (mode ? GAP + PUL : 0);
    chk(end_idx == expd, "R11 ready return cycle", end_idx, expd);
  endtask

  task automatic t_three_wire;
    run_frame(14'h2A5C, 1'b0, 1'b0, '0);
    run_frame(14'h3FFF, 1'b0, 1'b0, '0);
    run_frame(14'h0000, 1'b0, 1'b0, '0);
  endtask

  task automatic t_four_wire;
    run_frame(14'h1234, 1'b1, 1'b0, '0);
    run_frame(14'h2001, 1'b1, 1'b0, '0);
  endtask

  task automatic t_back_to_back;
    run_frame(14'h0F0F, 1'b0, 1'b1, 14'h30C3);
    run_frame(14'h30C3, 1'b1, 1'b1, 14'h0555);
    run_frame(14'h0555, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_powerup;
    t_three_wire;
    t_four_wire;
    t_back_to_back;
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule